// File: doc/BRIEF.md
# Interrupt Recognition and Entry Sequencer

This block is the interrupt front end of a small 8-bit processor core with a 16-bit address bus. It watches a level-sensitive, maskable interrupt request while ordinary instructions run. It decides at which instruction boundary the request is honoured. It then drives the memory bus through a fixed seven-cycle entry sequence. That sequence performs two dummy reads, pushes the return address and the status byte onto the stack page, and loads the new program counter from the interrupt vector.

Instruction execution lies outside the block. Each cycle, the execution unit, or a stub standing in for it, presents a count of the cycles left in the current instruction, including the present cycle. A value of 1 marks the final cycle, and 0 means that no instruction cycle is running. A request counts for the current instruction only if it is high at a clock edge before that instruction's final two cycles begin. A later request waits one more instruction. For this reason the delay from request to handler varies within a known window.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `bus_we` and `set_mask` are low, and no request is pending.
- R2: A request that is high and unmasked at the edge ending a cycle whose remaining count is 3 or more is taken at the end of that instruction. If it first appears in the cycle with remaining count k, the first handler cycle begins k+6 edges after the first edge that sees it.
- R3: A request that first appears in one of the final two cycles of an instruction (remaining count 2 or 1) is not taken at that boundary. The following instruction completes first, and entry starts at its end.
- R4: The delay from the first edge that sees a request to the start of the first handler cycle lies between 9 and 16 cycles for instruction lengths of 2 to 8.
- R5: `busy` is high for exactly 7 consecutive cycles per entry. Remaining-count values presented while `busy` is high have no effect on the sequence.
- R6: Entry cycles 1 and 2 are reads (`bus_we` low) at the return program counter, and they do not change it.
- R7: Entry cycles 3, 4 and 5 write, in this order, the return PC high byte, the return PC low byte and the status byte to address 0x0100 + SP. SP is decremented after each write, so `sp_out` ends at SP−3.
- R8: In the pushed status byte, bit 4 is 0 and bit 5 is 1. The other bits equal `status_in`.
- R9: Entry cycles 6 and 7 read 0xFFFE (low byte) and then 0xFFFF (high byte). After entry, `pc_out` equals {byte at 0xFFFF, byte at 0xFFFE}.
- R10: While `mask_in` is high, a request is ignored. A request held high until the mask clears is then taken, because the input is level-sensitive.
- R11: `set_mask` is high in entry cycles 6 and 7 only, after the status push. With the mask flag updated from it, a request still held high does not re-enter during the handler's first instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_req | input | 1 | Level-sensitive interrupt request |
| mask_in | input | 1 | Interrupt mask flag from the status register |
| cyc_left | input | 4 | Cycles left in the current instruction (1 = last, 0 = none) |
| status_in | input | 8 | Current status byte |
| pc_in | input | 16 | Address of the next instruction (return address) |
| sp_in | input | 8 | Current stack pointer |
| rd_data | input | 8 | Read data from memory |
| bus_addr | output | 16 | Memory address during entry |
| bus_wdata | output | 8 | Write data during entry |
| bus_we | output | 1 | Write strobe |
| sp_out | output | 8 | Stack pointer after the pushes |
| pc_out | output | 16 | Program counter, holding the vector after entry |
| set_mask | output | 1 | Request to set the mask flag |
| busy | output | 1 | High during the seven entry cycles |

## Verification
The hardest case to reach is a request that arrives exactly at the border of the recognition window. This is the cycle whose remaining count is 3 against the one whose count is 2, and it becomes harder still when the deferring instruction is the longest, 8-cycle kind. The stimulus comes from a stub that steps through each instruction's remaining count at negative edges. The stub raises the request in a chosen cycle of a chosen-length instruction and stalls the count while `busy` is high. The delays measured this way cover the 9 and 16 cycle extremes and several cases in between.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    ST_DUM0 = 3'd0,
    ST_DUM1 = 3'd1,
    ST_PCH  = 3'd2,
    ST_PCL  = 3'd3,
    ST_PSW  = 3'd4,
    ST_VLO  = 3'd5,
    ST_VHI  = 3'd6
  } entry_step_t;

  localparam int BRK_BIT  = 4;
  localparam int ONE_BIT  = 5;
endpackage

// File: rtl/irq_poll.sv
module irq_poll #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req,
  input  logic             mask_in,
  input  logic [LEN_W-1:0] cyc_left,
  input  logic             busy,
  output logic             take
);
  localparam logic [LEN_W-1:0] LAST  = LEN_W'(1);
  localparam logic [LEN_W-1:0] EARLY = LEN_W'(3);

  logic arm_q, arm_d;
  logic sample_en, boundary;

  always_comb begin
    boundary  = !busy && (cyc_left == LAST);
    sample_en = !busy && ((cyc_left >= EARLY) || (cyc_left == LAST));
    take      = boundary && arm_q;
    arm_d     = arm_q;
    if (take)
      arm_d = 1'b0;
    else if (sample_en)
      arm_d = irq_req && !mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      arm_q <= 1'b0;
    else
      arm_q <= arm_d;
  end

  // R10: a boundary reached with the mask held throughout never starts entry
  p_masked_no_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_in && $past(mask_in) && $past(mask_in, 2) && $past(mask_in, 3) &&
     $past(mask_in, 4) && $past(mask_in, 5) && $past(mask_in, 6) &&
     $past(mask_in, 7) && $past(mask_in, 8) && !busy) |-> !take);
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  output logic        busy,
  output entry_step_t step
);
  entry_step_t step_q, step_d;
  logic        busy_q, busy_d;

  always_comb begin
    step_d = step_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (step_q == ST_VHI) begin
        busy_d = 1'b0;
        step_d = ST_DUM0;
      end else begin
        step_d = entry_step_t'(step_q + 3'd1);
      end
    end else if (take) begin
      busy_d = 1'b1;
      step_d = ST_DUM0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= ST_DUM0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
    end
  end

  assign busy = busy_q;
  assign step = step_q;

  // R5: entry lasts exactly seven cycles
  p_entry_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |=> busy_q ##1 busy_q ##1 busy_q ##1 busy_q ##1 busy_q
                      ##1 busy_q ##1 !busy_q);
endmodule

// File: rtl/irq_bus_gen.sv
module irq_bus_gen
  import irq_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter int                 ADDR_W     = 16,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0]  VEC_ADDR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              busy,
  input  entry_step_t       step,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic [DATA_W-1:0] sp_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              set_mask
);
  localparam int               HI_W    = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [DATA_W-1:0] sp_q, sp_d;
  logic [DATA_W-1:0] psw_q, psw_d;
  logic [DATA_W-1:0] vlo_q, vlo_d;
  logic [DATA_W-1:0] psw_push;

  always_comb begin
    psw_push          = psw_q;
    psw_push[BRK_BIT] = 1'b0;
    psw_push[ONE_BIT] = 1'b1;
  end

  // next-state of the working registers
  always_comb begin
    pc_d  = pc_q;
    sp_d  = sp_q;
    psw_d = psw_q;
    vlo_d = vlo_q;
    if (!busy && take) begin
      pc_d  = pc_in;
      sp_d  = sp_in;
      psw_d = status_in;
    end else if (busy) begin
      case (step)
        ST_PCH, ST_PCL, ST_PSW: sp_d  = sp_q - DATA_W'(1);
        ST_VLO:                 vlo_d = rd_data;
        ST_VHI:                 pc_d  = {rd_data[HI_W-1:0], vlo_q};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= '0;
      psw_q <= '0;
      vlo_q <= '0;
    end else begin
      pc_q  <= pc_d;
      sp_q  <= sp_d;
      psw_q <= psw_d;
      vlo_q <= vlo_d;
    end
  end

  // bus drive for the current entry step
  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    set_mask  = 1'b0;
    if (busy) begin
      case (step)
        ST_DUM0, ST_DUM1: bus_addr = pc_q;
        ST_PCH: begin
          bus_addr  = {STACK_PAGE, sp_q};
          bus_wdata = pc_q[ADDR_W-1:DATA_W];
          bus_we    = 1'b1;
        end
        ST_PCL: begin
          bus_addr  = {STACK_PAGE, sp_q};
          bus_wdata = pc_q[DATA_W-1:0];
          bus_we    = 1'b1;
        end
        ST_PSW: begin
          bus_addr  = {STACK_PAGE, sp_q};
          bus_wdata = psw_push;
          bus_we    = 1'b1;
        end
        ST_VLO: begin
          bus_addr = VEC_ADDR;
          set_mask = 1'b1;
        end
        ST_VHI: begin
          bus_addr = VEC_HI;
          set_mask = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign sp_out = sp_q;
  assign pc_out = pc_q;

  // R7: writes land only in the stack page
  p_write_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_addr[ADDR_W-1:DATA_W] == STACK_PAGE);
  // R7: every push moves the stack pointer down by one
  p_sp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> sp_q == $past(sp_q) - DATA_W'(1));
  // R6: first entry cycle reads at the return address
  p_dummy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !bus_we && bus_addr == pc_q);
  // R9: program counter after entry is built from the two vector reads
  p_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> pc_q == {$past(rd_data[HI_W-1:0]), $past(rd_data, 2)});
  // R11: entry ends with the mask request raised
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(set_mask) && $past(set_mask, 2));
  // R8: status push clears bit 4 and sets bit 5
  p_psw_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_we) && $past(bus_we, 2)) |->
      !bus_wdata[BRK_BIT] && bus_wdata[ONE_BIT]);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int                 DATA_W     = 8,
  parameter int                 ADDR_W     = 16,
  parameter int                 LEN_W      = 4,
  parameter logic [DATA_W-1:0]  STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0]  VEC_ADDR   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic              mask_in,
  input  logic [LEN_W-1:0]  cyc_left,
  input  logic [DATA_W-1:0] status_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic [DATA_W-1:0] sp_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              set_mask,
  output logic              busy
);
  logic        take;
  entry_step_t step;

  irq_poll #(.LEN_W(LEN_W)) u_poll (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_req  (irq_req),
    .mask_in  (mask_in),
    .cyc_left (cyc_left),
    .busy     (busy),
    .take     (take)
  );

  irq_entry_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .busy  (busy),
    .step  (step)
  );

  irq_bus_gen #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .STACK_PAGE (STACK_PAGE),
    .VEC_ADDR   (VEC_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .busy      (busy),
    .step      (step),
    .status_in (status_in),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .rd_data   (rd_data),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .sp_out    (sp_out),
    .pc_out    (pc_out),
    .set_mask  (set_mask)
  );

  // R1: nothing is driven on the bus outside entry
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_we && !set_mask);
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic        mask_force = 1'b0;
  logic        mask_f = 1'b0;
  logic        clr_mask = 1'b0;
  logic [3:0]  cyc_left = 4'd0;
  logic [7:0]  status_v = 8'h00;
  logic [15:0] pc_v = 16'h0000;
  logic [7:0]  sp_v = 8'hFF;
  logic [15:0] vec_v = 16'h0000;
  logic [7:0]  rd_data;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, sp_out;
  logic        bus_we, set_mask, busy, mask_in;
  logic [15:0] pc_out;

  int cnt = 0;
  int tests = 0;
  int fails = 0;
  logic [15:0] la [0:7];
  logic [7:0]  ld [0:7];
  logic        lw [0:7];
  logic        lm [0:7];
  int nb, c, h;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;
  always @(posedge clk) if (clr_mask) mask_f <= 1'b0; else if (set_mask) mask_f <= 1'b1;
  assign mask_in = mask_f | mask_force;
  assign rd_data = (bus_addr == 16'hFFFE) ? vec_v[7:0] :
                   (bus_addr == 16'hFFFF) ? vec_v[15:8] : 8'hEA;

  irq_entry_seq uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_in(mask_in),
    .cyc_left(cyc_left), .status_in(status_v), .pc_in(pc_v), .sp_in(sp_v),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .sp_out(sp_out), .pc_out(pc_out),
    .set_mask(set_mask), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stub: present one instruction cycle, stalling while entry runs
  task automatic step(input int k);
    @(negedge clk);
    while (busy) begin
      cyc_left = 4'd0;
      @(negedge clk);
    end
    cyc_left = 4'(k);
  endtask

  task automatic run_instr(input int len);
    for (int j = len; j >= 1; j--) step(j);
  endtask

  task automatic clear_mask();
    @(negedge clk);
    cyc_left = 4'd0;
    clr_mask = 1'b1;
    @(negedge clk);
    clr_mask = 1'b0;
  endtask

  // collect the entry cycles; noise drives markers while busy
  task automatic wait_entry(input bit noise);
    nb = 0;
    h = -1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (busy) begin
        cyc_left = noise ? 4'd1 : 4'd0;
        if (nb < 8) begin
          la[nb] = bus_addr; ld[nb] = bus_wdata; lw[nb] = bus_we; lm[nb] = set_mask;
        end
        nb++;
      end else begin
        cyc_left = 4'd0;
        if (nb > 0) begin
          h = cnt;
          break;
        end
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy, "R1 busy in reset", busy, 0);
    chk(!bus_we && !set_mask, "R1 strobes in reset", {bus_we, set_mask}, 0);
    @(negedge clk); rst_n = 1'b1;
    irq_req = 1'b0;
    run_instr(4);
    @(negedge clk);
    chk(!busy, "R1 no pending after reset", busy, 0);
    cyc_left = 4'd0;
  endtask

  task automatic t_entry(input int l1, input int k, input int l2, input bit noise,
                         input logic [15:0] pc, input logic [7:0] sp,
                         input logic [7:0] st, input logic [15:0] vec, input string tag);
    int exp_lat;
    logic [7:0] exp_psw;
    irq_req = 1'b0;
    clear_mask();
    pc_v = pc; sp_v = sp; status_v = st; vec_v = vec;
    for (int j = l1; j >= 1; j--) begin
      step(j);
      if (j == k) begin irq_req = 1'b1; c = cnt; end
    end
    if (k <= 2) begin
      @(negedge clk);
      chk(!busy, {tag, " R3 not taken at first boundary"}, busy, 0);
      for (int j = l2; j >= 1; j--) begin
        if (j == l2) cyc_left = 4'(j); else step(j);
      end
    end
    wait_entry(noise);
    exp_lat = (k >= 3) ? k + 6 : k - 1 + l2 + 7;
    chk(h - (c + 1) == exp_lat, {tag, (k >= 3) ? " R2 latency" : " R3 latency"}, h - (c + 1), exp_lat);
    chk(exp_lat >= 9 && exp_lat <= 16 && h - (c + 1) == exp_lat, {tag, " R4 window"}, h - (c + 1), exp_lat);
    chk(nb == 7, {tag, " R5 busy length"}, nb, 7);
    chk(la[0] == pc && !lw[0] && la[1] == pc && !lw[1], {tag, " R6 dummy reads"}, la[1], pc);
    chk(lw[2] && la[2] == {8'h01, sp} && ld[2] == pc[15:8], {tag, " R7 push pch"}, {la[2], ld[2]}, {8'h01, sp, pc[15:8]});
    chk(lw[3] && la[3] == {8'h01, sp - 8'd1} && ld[3] == pc[7:0], {tag, " R7 push pcl"}, {la[3], ld[3]}, {8'h01, sp - 8'd1, pc[7:0]});
    exp_psw = (st & 8'hEF) | 8'h20;
    chk(lw[4] && la[4] == {8'h01, sp - 8'd2} && ld[4] == exp_psw, {tag, " R8 push status"}, ld[4], exp_psw);
    chk(sp_out == sp - 8'd3, {tag, " R7 sp_out"}, sp_out, sp - 8'd3);
    chk(!lw[5] && la[5] == 16'hFFFE && !lw[6] && la[6] == 16'hFFFF, {tag, " R9 vector reads"}, la[5], 16'hFFFE);
    chk(pc_out == vec, {tag, " R9 pc_out"}, pc_out, vec);
    chk(lm[5] && lm[6] && !lm[4] && !lm[0], {tag, " R11 set_mask timing"}, {lm[4], lm[5], lm[6]}, 3'b011);
    // request still high: the handler's first instruction must not re-enter
    run_instr(4);
    @(negedge clk);
    chk(!busy, {tag, " R11 no re-entry"}, busy, 0);
    cyc_left = 4'd0;
    irq_req = 1'b0;
  endtask

  task automatic t_masked();
    irq_req = 1'b0;
    clear_mask();
    mask_force = 1'b1;
    irq_req = 1'b1;
    run_instr(4); @(negedge clk); chk(!busy, "R10 masked after len 4", busy, 0);
    run_instr(2); @(negedge clk); chk(!busy, "R10 masked after len 2", busy, 0);
    run_instr(8); @(negedge clk); chk(!busy, "R10 masked after len 8", busy, 0);
    cyc_left = 4'd0;
    mask_force = 1'b0;
    vec_v = 16'h4455;
    run_instr(3);
    wait_entry(1'b0);
    chk(nb == 7, "R10 held request taken once unmasked", nb, 7);
    irq_req = 1'b0;
  endtask

  task automatic t_reset_mid();
    irq_req = 1'b0;
    clear_mask();
    irq_req = 1'b1;
    run_instr(3);
    repeat (3) @(negedge clk);
    cyc_left = 4'd0;
    chk(busy, "R5 entry running before reset", busy, 1);
    rst_n = 1'b0;
    irq_req = 1'b0;
    #1;
    chk(!busy && !bus_we, "R1 reset aborts entry", {busy, bus_we}, 0);
    @(negedge clk); rst_n = 1'b1;
    run_instr(5);
    @(negedge clk);
    chk(!busy, "R1 idle after mid-entry reset", busy, 0);
    cyc_left = 4'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_entry(4, 4, 0, 1'b0, 16'hC012, 8'hFD, 8'h34, 16'h8000, "basic");
    t_entry(3, 3, 0, 1'b0, 16'h1234, 8'h80, 8'hFF, 16'hA5C3, "min");
    t_entry(8, 5, 0, 1'b1, 16'h00FF, 8'h02, 8'h00, 16'h1001, "noise");
    t_entry(5, 2, 5, 1'b0, 16'h7F80, 8'h40, 8'hC3, 16'h2233, "defer2");
    t_entry(6, 1, 8, 1'b0, 16'hBEEF, 8'hFF, 8'h10, 16'hFACE, "defer1");
    t_entry(2, 2, 8, 1'b0, 16'h0102, 8'h10, 8'h81, 16'h0F0F, "max");
    t_masked();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule